// File: doc/BRIEF.md
# Port Pin Interrupt Trigger Unit

This block turns a group of general-purpose input pins into interrupt requests. Each channel has its own trigger setting made of two bits. A mode bit chooses edge or level sensing. A polarity bit chooses the active sense: high level or rising edge when set, and low level or falling edge when clear. The settings sit in two bus-visible registers, one holding all polarity bits and one holding all mode bits. Both registers can be written and read back.

Every pin passes through a synchronizer before it is used. A level-sensed channel drives its request for as long as the synchronized pin is at the active level. An edge-sensed channel latches its request when the chosen transition arrives, and the request stays set until the interrupt handler clears it through `irq_clr`. Writing a different value into a channel's mode or polarity bit drops that channel's pending request and restarts its edge history. This prevents a reconfiguration from producing a false edge.

There are two reset inputs. Cold reset returns both configuration registers to their defaults. Hot reset keeps the configuration and clears only the sampling and request state. Priority, masking and vectoring belong to the interrupt controller that consumes `irq_req`.

Top module: `pin_irq_trigger`

## Requirements
- R1: While `cold_rst_n` is low, both configuration registers read 0 and `irq_req` is 0. After any reset is released, no request appears before the second rising clock edge.
- R2: Configuration is written when `bus_sel` and `bus_wr` are high at a clock edge. Address 0 holds the polarity bits and address 1 holds the mode bits, with bit i belonging to channel i. `bus_rdata` returns the addressed register combinationally while `bus_sel` is high. Any other address reads 0 and ignores writes, and `bus_rdata` is 0 while `bus_sel` is low.
- R3: While `hot_rst_n` is low (and `cold_rst_n` is high), both configuration registers keep their values and ignore writes, and every pending request is cleared.
- R4: A channel with mode 0 and polarity 1 drives `irq_req[i]` high while its pin is high. The request follows the pin with a latency of two clock edges.
- R5: A channel with mode 0 and polarity 0 drives `irq_req[i]` high while its pin is low.
- R6: A channel with mode 1 and polarity 1 latches a request on a rising pin edge, visible after the third clock edge following the change. The request stays high after the pin returns low. A falling edge sets nothing.
- R7: A channel with mode 1 and polarity 0 latches a request on a falling pin edge. A rising edge sets nothing.
- R8: `irq_clr[i]` high at a clock edge clears the latched request of channel i only. It has no effect on a level-mode channel.
- R9: Writing a changed value into a channel's polarity or mode bit clears that channel's pending request and edge history. Rewriting the same value leaves a pending request in place.
- R10: A pin that is already at its active edge level when a reset is released produces no edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low; clears configuration and all state |
| hot_rst_n | input | 1 | Asynchronous hot reset, active low; clears state, keeps configuration |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register address (0 polarity, 1 mode) |
| bus_wdata | input | N_CH | Write data, one bit per channel |
| bus_rdata | output | N_CH | Read data of the addressed register |
| pin_in | input | N_CH | Asynchronous input pins |
| irq_clr | input | N_CH | Per-channel clear of latched edge requests |
| irq_req | output | N_CH | Per-channel interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, a two-stage synchronizer and a two-bit address. The two-bit address leaves the unused addresses 2 and 3 open to decode checks. With eight channels, one vector can hold all four trigger kinds side by side, so each comparison covers the whole request vector and shows that a channel's clear or reconfiguration leaves its neighbours alone. The two-stage depth fixes the exact latencies of two edges for level requests and three edges for edge requests, and the bench samples at those edges.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // register addresses inside the block's window
  localparam int unsigned REG_POL  = 0;
  localparam int unsigned REG_MODE = 1;

  // trigger kind formed from {mode, polarity}
  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'b00,
    TRIG_HIGH_LVL = 2'b01,
    TRIG_FALL     = 2'b10,
    TRIG_RISE     = 2'b11
  } trig_e;

  function automatic trig_e f_trig(input logic mode, input logic pol);
    return trig_e'({mode, pol});
  endfunction

  // level qualifies when the sample equals the chosen sense
  function automatic logic f_level_hit(input logic cur, input logic pol);
    return cur == pol;
  endfunction

  // a transition that ends on the chosen sense
  function automatic logic f_edge_hit(input logic prev, input logic cur, input logic pol);
    return (prev != cur) && (cur == pol);
  endfunction

endpackage

// File: rtl/pit_cfg_regs.sv
module pit_cfg_regs
  import pit_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              hot_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_CH-1:0]   bus_wdata,
  output logic [N_CH-1:0]   bus_rdata,
  output logic [N_CH-1:0]   pol_q,
  output logic [N_CH-1:0]   mode_q,
  output logic [N_CH-1:0]   cfg_chg
);

  logic hit_pol, hit_mode;
  logic wr_pol, wr_mode;

  assign hit_pol  = (bus_addr == ADDR_W'(REG_POL));
  assign hit_mode = (bus_addr == ADDR_W'(REG_MODE));

  // writes are held off while a hot reset is in progress
  assign wr_pol  = bus_sel & bus_wr & hot_rst_n & hit_pol;
  assign wr_mode = bus_sel & bus_wr & hot_rst_n & hit_mode;

  // channels whose setting is about to take a different value
  assign cfg_chg = (wr_pol  ? (bus_wdata ^ pol_q)  : '0)
                 | (wr_mode ? (bus_wdata ^ mode_q) : '0);

  // only the cold reset touches the configuration
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      pol_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= bus_wdata;
      if (wr_mode) mode_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (hit_pol)       bus_rdata = pol_q;
      else if (hit_mode) bus_rdata = mode_q;
    end
  end

endmodule

// File: rtl/pit_sync.sv
module pit_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic warm_done,
  input  logic cur,
  input  logic pol,
  input  logic mode,
  input  logic clr,
  input  logic chg,
  output logic req,
  output logic edge_evt
);

  logic prev_q;
  logic hist_ok_q;
  logic pend_q;

  // edge seen only once a trusted previous sample exists
  assign edge_evt = warm_done & hist_ok_q & f_edge_hit(prev_q, cur, pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      hist_ok_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      prev_q <= cur;
      if (chg) hist_ok_q <= 1'b0;
      else     hist_ok_q <= warm_done;
      // reconfiguration drops the request, a new edge wins over clear
      if (chg)                  pend_q <= 1'b0;
      else if (mode & edge_evt) pend_q <= 1'b1;
      else if (clr)             pend_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (f_trig(mode, pol))
      TRIG_LOW_LVL:  req = warm_done & f_level_hit(cur, 1'b0);
      TRIG_HIGH_LVL: req = warm_done & f_level_hit(cur, 1'b1);
      TRIG_FALL,
      TRIG_RISE:     req = pend_q;
      default:       req = 1'b0;
    endcase
  end

endmodule

// File: rtl/pin_irq_trigger.sv
module pin_irq_trigger
  import pit_pkg::*;
#(
  parameter int unsigned N_CH        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              hot_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_CH-1:0]   bus_wdata,
  output logic [N_CH-1:0]   bus_rdata,
  input  logic [N_CH-1:0]   pin_in,
  input  logic [N_CH-1:0]   irq_clr,
  output logic [N_CH-1:0]   irq_req
);

  localparam int unsigned WARM_W = $clog2(SYNC_STAGES + 1);

  logic              rst_dp_n;
  logic [N_CH-1:0]   pol_q, mode_q, cfg_chg;
  logic [N_CH-1:0]   sync_q;
  logic [N_CH-1:0]   edge_evt;
  logic [WARM_W-1:0] warm_cnt_q;
  logic              warm_done;

  // datapath state falls under either reset
  assign rst_dp_n = cold_rst_n & hot_rst_n;

  pit_cfg_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .cold_rst_n(cold_rst_n),
    .hot_rst_n (hot_rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pol_q     (pol_q),
    .mode_q    (mode_q),
    .cfg_chg   (cfg_chg)
  );

  pit_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_dp_n),
    .d    (pin_in),
    .q    (sync_q)
  );

  // samples are trusted once the synchronizer has refilled
  assign warm_done = (warm_cnt_q == WARM_W'(SYNC_STAGES));

  always_ff @(posedge clk or negedge rst_dp_n) begin
    if (!rst_dp_n)      warm_cnt_q <= '0;
    else if (!warm_done) warm_cnt_q <= warm_cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    pit_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_dp_n),
      .warm_done(warm_done),
      .cur      (sync_q[i]),
      .pol      (pol_q[i]),
      .mode     (mode_q[i]),
      .clr      (irq_clr[i]),
      .chg      (cfg_chg[i]),
      .req      (irq_req[i]),
      .edge_evt (edge_evt[i])
    );
  end

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk,
  input logic            rst_dp_n,
  input logic            cold_rst_n,
  input logic            hot_rst_n,
  input logic            warm_done,
  input logic [N_CH-1:0] irq_clr,
  input logic [N_CH-1:0] irq_req,
  input logic [N_CH-1:0] pol_q,
  input logic [N_CH-1:0] mode_q,
  input logic [N_CH-1:0] sync_q,
  input logic [N_CH-1:0] cfg_chg,
  input logic [N_CH-1:0] edge_evt
);

  // R1: nothing is requested until the synchronizer has refilled
  p_quiet_warm_r1: assert property (@(posedge clk) disable iff (!rst_dp_n)
    !warm_done |-> irq_req == '0);

  // R3: hot reset leaves the configuration untouched
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !hot_rst_n |=> ($stable(pol_q) && $stable(mode_q)));

  // R4 / R5: level channels mirror the qualified synchronized sample
  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_dp_n)
    warm_done |-> ((irq_req & ~mode_q) == (~mode_q & ~(sync_q ^ pol_q))));

  // R6: an edge request only rises after a detected edge
  p_edge_cause_r6: assert property (@(posedge clk) disable iff (!rst_dp_n)
    1'b1 |=> ((irq_req & mode_q & ~$past(irq_req) & ~$past(edge_evt)) == '0));

  // R8: a latched request persists without a clear or reconfiguration
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_dp_n)
    1'b1 |=> (($past(irq_req & mode_q & ~irq_clr & ~cfg_chg) & ~irq_req) == '0));

  // R9: reconfiguration empties the request and suppresses the next edge
  p_reconf_r9: assert property (@(posedge clk) disable iff (!rst_dp_n)
    1'b1 |=> ((($past(cfg_chg) & irq_req & mode_q) == '0)
              && (($past(cfg_chg) & edge_evt) == '0)));

endmodule

bind pin_irq_trigger pit_checker #(.N_CH(N_CH)) u_pit_chk (
  .clk       (clk),
  .rst_dp_n  (rst_dp_n),
  .cold_rst_n(cold_rst_n),
  .hot_rst_n (hot_rst_n),
  .warm_done (warm_done),
  .irq_clr   (irq_clr),
  .irq_req   (irq_req),
  .pol_q     (pol_q),
  .mode_q    (mode_q),
  .sync_q    (sync_q),
  .cfg_chg   (cfg_chg),
  .edge_evt  (edge_evt)
);

// File: tb/pin_irq_trigger_bench.sv
module pin_irq_trigger_bench;

  localparam int N = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          cold_rst_n = 1'b0;
  logic          hot_rst_n = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  irq_clr = '0;
  logic [N-1:0]  irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pin_irq_trigger #(.N_CH(N), .SYNC_STAGES(2), .ADDR_W(AW)) u_pin_irq_trigger (
    .clk, .cold_rst_n, .hot_rst_n, .bus_sel, .bus_wr, .bus_addr,
    .bus_wdata, .bus_rdata, .pin_in, .irq_clr, .irq_req
  );

  // level qualification restated: request where pin equals the sense bit
  function automatic logic [N-1:0] lvl_model(input logic [N-1:0] pins, input logic [N-1:0] sense);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (pins[i] === sense[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse_clr(input logic [N-1:0] m);
    irq_clr = m;
    step(1);
    irq_clr = '0;
  endtask

  task automatic t_cold_reset;
    logic [N-1:0] d;
    cold_rst_n = 1'b0; pin_in = '0;
    step(3);
    check("R1 req in cold reset", irq_req, '0);
    bus_read(2'd0, d); check("R1 polarity default", d, '0);
    bus_read(2'd1, d); check("R1 mode default", d, '0);
    cold_rst_n = 1'b1;
    step(1);
    check("R1 quiet one edge after release", irq_req, '0);
    step(1);
    check("R5 default low level active", irq_req, 8'hFF);
  endtask

  task automatic t_regmap;
    logic [N-1:0] d;
    bus_write(2'd0, 8'hA5);
    bus_write(2'd1, 8'h3C);
    bus_read(2'd0, d); check("R2 polarity readback", d, 8'hA5);
    bus_read(2'd1, d); check("R2 mode readback", d, 8'h3C);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd0, d); check("R2 polarity after stray write", d, 8'hA5);
    bus_read(2'd1, d); check("R2 mode after stray write", d, 8'h3C);
    bus_read(2'd2, d); check("R2 unused address reads zero", d, '0);
    bus_addr = 2'd0; #1;
    check("R2 rdata idle when unselected", bus_rdata, '0);
  endtask

  task automatic t_level_high;
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'hFF);
    pin_in = '0;
    step(2);
    check("R4 inactive pins", irq_req, lvl_model(pin_in, 8'hFF));
    pin_in = 8'h08;
    step(1);
    check("R4 not yet after one edge", irq_req, '0);
    step(1);
    check("R4 high after two edges", irq_req, 8'h08);
    pulse_clr(8'h08);
    check("R8 clear ignored in level mode", irq_req, 8'h08);
    pin_in = '0;
    step(2);
    check("R4 drops with pin", irq_req, '0);
  endtask

  task automatic t_level_low;
    bus_write(2'd0, 8'h00);
    pin_in = 8'hF0;
    step(2);
    check("R5 low level", irq_req, lvl_model(8'hF0, 8'h00));
    pin_in = 8'h0F;
    step(2);
    check("R5 low level swapped", irq_req, 8'hF0);
  endtask

  task automatic t_edge_rise;
    pin_in = '0;
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'hFF);
    step(3);
    check("R6 idle after setup", irq_req, '0);
    pin_in = 8'h01;
    step(2);
    check("R6 not yet at two edges", irq_req, '0);
    step(1);
    check("R6 rising latched", irq_req, 8'h01);
    pin_in = 8'h00;
    step(3);
    check("R6 held after pin falls", irq_req, 8'h01);
    pulse_clr(8'h02);
    check("R8 clear of other channel", irq_req, 8'h01);
    pulse_clr(8'h01);
    check("R8 clear own channel", irq_req, '0);
    pin_in = 8'h04;
    step(3);
    check("R6 second rise", irq_req, 8'h04);
    pulse_clr(8'h04);
    pin_in = 8'h00;
    step(3);
    check("R6 falling ignored", irq_req, '0);
  endtask

  task automatic t_edge_fall;
    pin_in = 8'hFF;
    step(3);
    bus_write(2'd0, 8'h00);
    step(3);
    check("R7 idle after setup", irq_req, '0);
    pin_in = 8'hDF;
    step(2);
    check("R7 not yet at two edges", irq_req, '0);
    step(1);
    check("R7 falling latched", irq_req, 8'h20);
    pin_in = 8'hFF;
    step(3);
    check("R7 rising ignored, held", irq_req, 8'h20);
    pulse_clr(8'h20);
    check("R8 clear falling request", irq_req, '0);
  endtask

  task automatic t_reconfig;
    pin_in = 8'hBF;
    step(3);
    pin_in = 8'hFF;
    step(3);
    check("R9 pending before rewrite", irq_req, 8'h40);
    bus_write(2'd0, 8'h00);
    check("R9 same value keeps pending", irq_req, 8'h40);
    bus_write(2'd0, 8'h40);
    check("R9 changed bit clears pending", irq_req, '0);
    step(3);
    check("R9 no false edge after change", irq_req, '0);
    pin_in = 8'hBF;
    step(3);
    check("R9 new sense ignores fall", irq_req, '0);
    pin_in = 8'hFF;
    step(3);
    check("R9 new sense takes rise", irq_req, 8'h40);
  endtask

  task automatic t_hot_reset;
    logic [N-1:0] d;
    hot_rst_n = 1'b0;
    step(1);
    check("R3 pending cleared by hot reset", irq_req, '0);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
    step(1);
    hot_rst_n = 1'b1;
    bus_read(2'd0, d); check("R3 polarity kept", d, 8'h40);
    bus_read(2'd1, d); check("R3 mode kept", d, 8'hFF);
    step(5);
    check("R10 no edge from high pin at release", irq_req, '0);
  endtask

  task automatic t_cold_again;
    logic [N-1:0] d;
    cold_rst_n = 1'b0;
    step(1);
    bus_read(2'd0, d); check("R1 cold clears polarity", d, '0);
    bus_read(2'd1, d); check("R1 cold clears mode", d, '0);
    cold_rst_n = 1'b1;
    step(3);
    check("R10 level default after cold with pins high", irq_req, '0);
  endtask

  initial begin
    @(negedge clk);
    t_cold_reset();
    t_regmap();
    t_level_high();
    t_level_low();
    t_edge_rise();
    t_edge_fall();
    t_reconfig();
    t_hot_reset();
    t_cold_again();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule